// File: doc/BRIEF.md
# Set-Associative Cache Hit/Miss Tracker

This block is a tag-only model of a set-associative cache. It observes a stream of read accesses and reports whether each one would hit or miss, so that the external traffic a real cache would cause can be estimated from the miss count. Each access carries a byte address that has already been mapped, a picture identifier and a colour-component identifier. No data is stored. Only the tags, a valid bit for each entry and the statistics are kept.

The block splits the byte address into a line address and a set index, and compares every way of the selected set in parallel. The choice of victim is left to an external replacement policy. The block shows the policy the set being looked up, takes a victim way back, and reports each way it uses in the same cycle. Running counters cover misses, total accesses and hits per entry. A frame strobe adds the per-frame figures into wider sequence-level totals. A clear input wipes the frame state, and an enable input lets whole stretches of accesses be ignored.

Top module: `cache_hit_tracker`

## Requirements
- R1: The line address is `acc_addr` shifted right by log2(LINE_BYTES). The set index is the line address modulo NUM_SETS and is shown on `lookup_set` in the same cycle as the access.
- R2: An entry hits only if it is valid and its stored line address, picture identifier and component identifier all equal those of the access. A change in any one of the three gives a miss.
- R3: On a miss, `miss_cnt` rises by one. The victim way of the set then holds the access's line address, picture id and component id, and is marked valid. The victim is `victim_way`, or way 0 when NUM_WAYS is 1.
- R4: On a hit, the hit counter of the matching entry rises by one. Entry counters are read through `rd_entry`, where entry index = set × NUM_WAYS + way.
- R5: When NUM_WAYS > 1, every accepted access raises `touch_valid` in the same cycle. `touch_way` gives the hitting way on a hit and the victim way on a miss. If several ways match, the lowest-numbered one is used.
- R6: Each accepted access (`enable` and `acc_valid` high, `clear` low) adds one to `total_cnt`. While `enable` is low, accesses change no counter and no entry.
- R7: `clear` invalidates all entries and zeroes the entry hit counters, `miss_cnt` and `total_cnt`. An access in the same cycle is dropped.
- R8: `frame_acc` adds the sum of all entry hit counters to `seq_hits`, `miss_cnt` to `seq_misses` and `total_cnt` to `seq_total`. It uses the values from before that cycle's update.
- R9: `seq_ovf` is set when `total_cnt` wraps from its maximum to zero. It stays set until reset, and `clear` does not affect it.
- R10: One cycle after an accepted access, `res_valid` is high and `res_hit` and `res_way` give the outcome, where `res_way` is the hit way or the filled way. `res_valid` is low in any cycle that does not follow an accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Accesses are processed only while high |
| clear | input | 1 | Invalidate entries and zero the frame counters |
| frame_acc | input | 1 | Add frame counters into sequence counters |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Mapped byte address |
| acc_pic | input | PIC_W | Picture identifier |
| acc_comp | input | COMP_W | Colour-component identifier |
| lookup_set | output | SET_W | Set index of the current address |
| victim_way | input | WAY_W | Victim chosen by the replacement policy |
| touch_valid | output | 1 | Way-use report to the policy |
| touch_way | output | WAY_W | Way used by this access |
| res_valid | output | 1 | Registered result strobe |
| res_hit | output | 1 | Result: hit |
| res_way | output | WAY_W | Result: hit way or filled way |
| miss_cnt | output | CNT_W | Frame miss counter |
| total_cnt | output | CNT_W | Frame access counter |
| rd_entry | input | ENT_W | Entry selected for hit-count readout |
| rd_hits | output | CNT_W | Hit count of the selected entry |
| seq_hits | output | SEQ_W | Sequence hit total |
| seq_misses | output | SEQ_W | Sequence miss total |
| seq_total | output | SEQ_W | Sequence access total |
| seq_ovf | output | 1 | Sticky frame-total wrap flag |

## Verification
The assertions assume a well-behaved policy. `victim_way` must be below NUM_WAYS whenever an access is presented, and the control inputs must hold steady from one falling edge to the next. The bench meets both conditions. It drives every input on the falling edge and draws victims only from the legal range of ways. Addresses are confined to a few dozen lines and picture and component ids to small ranges, so that hits, misses, evictions and a wrap of the frame total all occur.

// File: rtl/trk_pkg.sv
package trk_pkg;
    // Index width that stays at least one bit for a count of one.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/trk_tag_store.sv
module trk_tag_store #(
    parameter  int SETS   = 32,
    parameter  int WAYS   = 4,
    parameter  int LINE_W = 25,
    parameter  int PIC_W  = 8,
    parameter  int COMP_W = 2,
    localparam int SET_W  = trk_pkg::idx_w(SETS),
    localparam int WAY_W  = trk_pkg::idx_w(WAYS),
    localparam int ENT    = SETS * WAYS,
    localparam int ENT_W  = trk_pkg::idx_w(ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [SET_W-1:0]  set_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [PIC_W-1:0]  pic_i,
    input  logic [COMP_W-1:0] comp_i,
    input  logic              fill_i,
    input  logic [WAY_W-1:0]  fill_way_i,
    output logic              hit_o,
    output logic [WAY_W-1:0]  hit_way_o
);
    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
        logic [PIC_W-1:0]  pic;
        logic [COMP_W-1:0] comp;
    } tag_t;

    tag_t tags_d [ENT];
    tag_t tags_q [ENT];

    logic [ENT_W-1:0] base;
    logic [WAYS-1:0]  match;

    assign base = ENT_W'(int'(set_i) * WAYS);

    // One comparator per way, all working on the selected set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        tag_t t;
        assign t        = tags_q[base + ENT_W'(w)];
        assign match[w] = t.vld && (t.line == line_i) && (t.pic == pic_i) && (t.comp == comp_i);
    end

    // Lowest-numbered matching way wins.
    always_comb begin
        hit_o     = 1'b0;
        hit_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_o     = 1'b1;
                hit_way_o = WAY_W'(w);
            end
        end
    end

    always_comb begin
        tags_d = tags_q;
        if (clear_i) begin
            for (int e = 0; e < ENT; e++) tags_d[e].vld = 1'b0;
        end else if (fill_i) begin
            tags_d[base + ENT_W'(fill_way_i)] = '{vld: 1'b1, line: line_i, pic: pic_i, comp: comp_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENT; e++) tags_q[e] <= '0;
        end else begin
            tags_q <= tags_d;
        end
    end
endmodule

// File: rtl/trk_entry_counters.sv
module trk_entry_counters #(
    parameter  int ENT   = 128,
    parameter  int CNT_W = 16,
    localparam int ENT_W = trk_pkg::idx_w(ENT),
    localparam int SUM_W = CNT_W + ENT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    input  logic [ENT_W-1:0] inc_idx_i,
    input  logic [ENT_W-1:0] rd_idx_i,
    output logic [CNT_W-1:0] rd_val_o,
    output logic [SUM_W-1:0] sum_o
);
    logic [CNT_W-1:0] cnt_d [ENT];
    logic [CNT_W-1:0] cnt_q [ENT];

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            for (int e = 0; e < ENT; e++) cnt_d[e] = '0;
        end else if (inc_i) begin
            cnt_d[inc_idx_i] = cnt_q[inc_idx_i] + 1'b1;
        end
    end

    always_comb begin
        sum_o = '0;
        for (int e = 0; e < ENT; e++) sum_o = sum_o + SUM_W'(cnt_q[e]);
    end

    assign rd_val_o = cnt_q[rd_idx_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENT; e++) cnt_q[e] <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cache_hit_tracker.sv
module cache_hit_tracker #(
    parameter  int LINE_BYTES = 128,
    parameter  int NUM_SETS   = 32,
    parameter  int NUM_WAYS   = 4,
    parameter  int ADDR_W     = 32,
    parameter  int PIC_W      = 8,
    parameter  int COMP_W     = 2,
    parameter  int CNT_W      = 16,
    parameter  int SEQ_W      = 40,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int LINE_W     = ADDR_W - OFF_W,
    localparam int SET_W      = trk_pkg::idx_w(NUM_SETS),
    localparam int WAY_W      = trk_pkg::idx_w(NUM_WAYS),
    localparam int ENT        = NUM_SETS * NUM_WAYS,
    localparam int ENT_W      = trk_pkg::idx_w(ENT),
    localparam int SUM_W      = CNT_W + ENT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              clear,
    input  logic              frame_acc,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [PIC_W-1:0]  acc_pic,
    input  logic [COMP_W-1:0] acc_comp,
    output logic [SET_W-1:0]  lookup_set,
    input  logic [WAY_W-1:0]  victim_way,
    output logic              touch_valid,
    output logic [WAY_W-1:0]  touch_way,
    output logic              res_valid,
    output logic              res_hit,
    output logic [WAY_W-1:0]  res_way,
    output logic [CNT_W-1:0]  miss_cnt,
    output logic [CNT_W-1:0]  total_cnt,
    input  logic [ENT_W-1:0]  rd_entry,
    output logic [CNT_W-1:0]  rd_hits,
    output logic [SEQ_W-1:0]  seq_hits,
    output logic [SEQ_W-1:0]  seq_misses,
    output logic [SEQ_W-1:0]  seq_total,
    output logic              seq_ovf
);
    typedef struct packed {
        logic [CNT_W-1:0] miss;
        logic [CNT_W-1:0] total;
        logic [SEQ_W-1:0] s_hits;
        logic [SEQ_W-1:0] s_miss;
        logic [SEQ_W-1:0] s_total;
        logic             ovf;
        logic             r_vld;
        logic             r_hit;
        logic [WAY_W-1:0] r_way;
    } stat_t;

    stat_t st_d, st_q;

    logic [LINE_W-1:0] line_addr;
    logic              take;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  vict;
    logic [WAY_W-1:0]  used_way;
    logic [ENT_W-1:0]  hit_idx;
    logic [SUM_W-1:0]  hit_sum;
    logic              unused_offset;

    assign line_addr     = acc_addr[ADDR_W-1:OFF_W];
    assign unused_offset = ^acc_addr[OFF_W-1:0];
    assign lookup_set    = SET_W'(line_addr % LINE_W'(NUM_SETS));
    assign take          = enable && acc_valid && !clear;
    assign used_way      = hit ? hit_way : vict;
    assign hit_idx       = ENT_W'(int'(lookup_set) * NUM_WAYS + int'(hit_way));
    assign touch_way     = used_way;

    if (NUM_WAYS == 1) begin : g_single
        logic unused_victim;
        assign unused_victim = ^victim_way;
        assign vict          = '0;
        assign touch_valid   = 1'b0;
    end else begin : g_multi
        assign vict          = victim_way;
        assign touch_valid   = take;
    end

    trk_tag_store #(
        .SETS(NUM_SETS), .WAYS(NUM_WAYS), .LINE_W(LINE_W), .PIC_W(PIC_W), .COMP_W(COMP_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .set_i      (lookup_set),
        .line_i     (line_addr),
        .pic_i      (acc_pic),
        .comp_i     (acc_comp),
        .fill_i     (take && !hit),
        .fill_way_i (vict),
        .hit_o      (hit),
        .hit_way_o  (hit_way)
    );

    trk_entry_counters #(
        .ENT(ENT), .CNT_W(CNT_W)
    ) u_hits (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .inc_i     (take && hit),
        .inc_idx_i (hit_idx),
        .rd_idx_i  (rd_entry),
        .rd_val_o  (rd_hits),
        .sum_o     (hit_sum)
    );

    always_comb begin
        st_d       = st_q;
        st_d.r_vld = take;
        st_d.r_hit = take && hit;
        st_d.r_way = take ? used_way : '0;
        if (frame_acc) begin
            st_d.s_hits  = st_q.s_hits  + SEQ_W'(hit_sum);
            st_d.s_miss  = st_q.s_miss  + SEQ_W'(st_q.miss);
            st_d.s_total = st_q.s_total + SEQ_W'(st_q.total);
        end
        if (clear) begin
            st_d.miss  = '0;
            st_d.total = '0;
        end else if (take) begin
            st_d.total = st_q.total + 1'b1;
            if (st_q.total == '1) st_d.ovf = 1'b1;
            if (!hit) st_d.miss = st_q.miss + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid  = st_q.r_vld;
    assign res_hit    = st_q.r_hit;
    assign res_way    = st_q.r_way;
    assign miss_cnt   = st_q.miss;
    assign total_cnt  = st_q.total;
    assign seq_hits   = st_q.s_hits;
    assign seq_misses = st_q.s_miss;
    assign seq_total  = st_q.s_total;
    assign seq_ovf    = st_q.ovf;
endmodule

// File: rtl/trk_checker.sv
module trk_checker #(
    parameter int CNT_W = 16,
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             clear,
    input logic             acc_valid,
    input logic             touch_valid,
    input logic             res_valid,
    input logic             res_hit,
    input logic [WAY_W-1:0] res_way,
    input logic [CNT_W-1:0] miss_cnt,
    input logic [CNT_W-1:0] total_cnt,
    input logic             seq_ovf
);
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (miss_cnt == '0) && (total_cnt == '0) && !res_valid);

    p_disabled_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clear) |=> $stable(total_cnt) && $stable(miss_cnt) && !res_valid);

    p_total_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && acc_valid && !clear) |=> total_cnt == $past(total_cnt) + 1'b1);

    p_miss_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> miss_cnt == $past(miss_cnt) + 1'b1);

    p_touch_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        touch_valid |-> (enable && acc_valid && !clear));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seq_ovf) |-> seq_ovf);
endmodule

bind cache_hit_tracker trk_checker #(.CNT_W(CNT_W), .WAY_W(WAY_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .clear       (clear),
    .acc_valid   (acc_valid),
    .touch_valid (touch_valid),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_way     (res_way),
    .miss_cnt    (miss_cnt),
    .total_cnt   (total_cnt),
    .seq_ovf     (seq_ovf)
);

// File: tb/cache_hit_tracker_tb.sv
module cache_hit_tracker_tb;
    localparam int LB = 16, SETS = 4, WAYS = 4, AW = 16, PW = 2, CW = 2, CNTW = 10, SEQW = 32;
    localparam int ENT = SETS * WAYS;
    localparam int CMASK = (1 << CNTW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic enable = 1'b0, clear = 1'b0, frame_acc = 1'b0, acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [PW-1:0] acc_pic = '0;
    logic [CW-1:0] acc_comp = '0;
    logic [1:0] victim_way = '0, touch_way, res_way, lookup_set;
    logic touch_valid, res_valid, res_hit, seq_ovf;
    logic [CNTW-1:0] miss_cnt, total_cnt, rd_hits;
    logic [3:0] rd_entry = '0;
    logic [SEQW-1:0] seq_hits, seq_misses, seq_total;

    always #2.5 clk = ~clk;

    cache_hit_tracker #(.LINE_BYTES(LB), .NUM_SETS(SETS), .NUM_WAYS(WAYS), .ADDR_W(AW),
        .PIC_W(PW), .COMP_W(CW), .CNT_W(CNTW), .SEQ_W(SEQW)) u_dut (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit m_v [ENT];
    int m_line [ENT], m_pic [ENT], m_comp [ENT], m_hits [ENT];
    int m_miss = 0, m_total = 0;
    longint s_hits = 0, s_miss = 0, s_total = 0;
    bit m_ovf = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int find_way(input int line, input int pic, input int comp);
        int s = line % SETS;
        for (int w = 0; w < WAYS; w++)
            if (m_v[s*WAYS+w] && m_line[s*WAYS+w] == line && m_pic[s*WAYS+w] == pic && m_comp[s*WAYS+w] == comp)
                return w;
        return -1;
    endfunction

    function automatic longint hit_sum();
        longint t = 0;
        for (int e = 0; e < ENT; e++) t += m_hits[e];
        return t;
    endfunction

    task automatic access(input int addr, input int pic, input int comp, input int vict, input bit en);
        int line, set, hw, way;
        @(negedge clk);
        enable = en; clear = 0; frame_acc = 0; acc_valid = 1;
        acc_addr = AW'(addr); acc_pic = PW'(pic); acc_comp = CW'(comp); victim_way = 2'(vict);
        #1;
        line = addr / LB; set = line % SETS; hw = find_way(line, pic, comp);
        way = (hw >= 0) ? hw : vict;
        chk("R1 set index", lookup_set, set);
        chk("R5 touch valid", touch_valid, en);
        if (en) chk("R5 touch way", touch_way, way);
        @(posedge clk); #1;
        acc_valid = 0;
        if (en) begin
            if (hw >= 0) m_hits[set*WAYS+hw] = (m_hits[set*WAYS+hw] + 1) & CMASK;
            else begin
                m_miss = (m_miss + 1) & CMASK;
                m_v[set*WAYS+vict] = 1; m_line[set*WAYS+vict] = line;
                m_pic[set*WAYS+vict] = pic; m_comp[set*WAYS+vict] = comp;
            end
            if (m_total == CMASK) m_ovf = 1;
            m_total = (m_total + 1) & CMASK;
            chk("R2 hit flag", res_hit, hw >= 0);
            chk("R10 result way", res_way, way);
        end
        chk("R10 result valid", res_valid, en);
        chk("R3 miss count", miss_cnt, m_miss);
        chk("R6 total count", total_cnt, m_total);
    endtask

    task automatic read_all();
        for (int e = 0; e < ENT; e++) begin
            @(negedge clk); rd_entry = 4'(e); #1;
            chk("R4 entry hits", rd_hits, m_hits[e]);
        end
    endtask

    task automatic frame();
        @(negedge clk); frame_acc = 1; acc_valid = 0;
        @(posedge clk); #1; frame_acc = 0;
        s_hits += hit_sum(); s_miss += m_miss; s_total += m_total;
        chk("R8 seq hits", seq_hits, s_hits);
        chk("R8 seq misses", seq_misses, s_miss);
        chk("R8 seq total", seq_total, s_total);
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1; enable = 1; acc_valid = 1; acc_addr = 16'h0100;
        @(posedge clk); #1; clear = 0; acc_valid = 0;
        for (int e = 0; e < ENT; e++) begin m_v[e] = 0; m_hits[e] = 0; end
        m_miss = 0; m_total = 0;
        chk("R7 miss zero", miss_cnt, 0);
        chk("R7 total zero", total_cnt, 0);
        chk("R7 access dropped", res_valid, 0);
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int e = 0; e < ENT; e++) begin m_v[e] = 0; m_hits[e] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R10 reset valid", res_valid, 0);
        chk("R3 reset miss", miss_cnt, 0);
        chk("R6 reset total", total_cnt, 0);
        chk("R9 reset ovf", seq_ovf, 0);
        // R2: same line, differing picture or component
        access(16'h0100, 0, 0, 2, 1);
        access(16'h0100, 0, 0, 1, 1);
        access(16'h0100, 1, 0, 1, 1);
        access(16'h0100, 0, 1, 3, 1);
        access(16'h0100, 0, 0, 0, 1);
        access(16'h0104, 1, 0, 0, 1);   // R1 offset bits ignored
        access(16'h0140, 0, 0, 0, 1);   // same set, new line
        access(16'h0140, 0, 0, 3, 1);
        read_all();
        frame();
        // R6: disabled access leaves no entry
        access(16'h0200, 0, 0, 0, 0);
        access(16'h0200, 0, 0, 0, 1);
        do_clear();
        access(16'h0100, 0, 0, 1, 1);   // R7: previous entries gone
        frame();
        for (int i = 0; i < 1100; i++) begin
            access(int'($urandom % (LB * SETS * 6)), int'($urandom % 2), int'($urandom % 2),
                   int'($urandom % WAYS), ($urandom % 16) != 0);
            if (i % 250 == 249) frame();
        end
        read_all();
        frame();
        chk("R9 overflow set", seq_ovf, m_ovf);
        chk("R9 overflow expected", m_ovf, 1);
        do_clear();
        chk("R9 overflow sticky", seq_ovf, 1);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule